// File: doc/BRIEF.md
# UART Receive Buffer with Threshold DMA Request and Idle Timeout

This block stores the bytes a UART deserializer recovers in a 64-entry first-in, first-out buffer. It raises a DMA request while the stored count is at or above a selectable trigger level. The request can be masked by an enable input, and masking it leaves the stored data untouched.

A few bytes can remain below the trigger level after the line goes quiet. These are never requested. An idle timer counts bit-time ticks and raises a character-timeout indication after four character times of silence, taking ten bit times per character. That indication reaches the interrupt pin only when its enable is set. Software then drains the remaining bytes one at a time until the data-ready flag falls.

The write side is a valid/ready stream. `in_ready` is advisory: the deserializer cannot stall, so a byte presented while `in_ready` is low is dropped and a sticky overrun flag is set. The read side is also valid/ready. `rd_data` shows the oldest byte while `rd_valid` is high, and one byte leaves on every clock edge where both `rd_valid` and `rd_ready` are high. `rd_valid` serves as the data-ready flag.

Top module: `uart_rxbuf`

## Requirements
- R1: Bytes leave in the order they were accepted. `rd_valid` is high exactly when at least one byte is stored, and it falls in the cycle after the last byte is popped.
- R2: `in_ready` is high while fewer than 64 bytes are stored. A byte presented while the buffer is full is dropped and sets `overrun`. `overrun` stays set until a cycle with `status_rd` high.
- R3: `dma_req` is high when `dma_en` is high and the stored count is at or above the trigger level. `trig_sel` selects that level: 0 gives 1 entry, 1 gives 8, 2 gives 16 and 3 gives 32.
- R4: With a stored count below the trigger level, `dma_req` stays low and the stored bytes remain readable.
- R5: `dma_en` affects only `dma_req`. Toggling it never changes the stored bytes or their count.
- R6: With the buffer non-empty and no incoming byte or pop, the character-timeout indication is set on the 40th `bit_tick`. It is never set while the buffer is empty.
- R7: `tout_irq` shows the timeout indication only while `tout_ie` is high. An indication raised while `tout_ie` is low appears as soon as `tout_ie` is raised.
- R8: The timeout indication clears on any pop and on any newly presented byte. The idle count then restarts from zero.
- R9: After reset the buffer is empty, and `rd_valid`, `dma_req`, `tout_irq` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Room for a byte (advisory) |
| bit_tick | input | 1 | One pulse per serial bit time |
| rd_valid | output | 1 | Data-ready: at least one byte stored |
| rd_data | output | 8 | Oldest stored byte |
| rd_ready | input | 1 | Pop strobe |
| trig_sel | input | 2 | Trigger level select |
| dma_en | input | 1 | Receive DMA request enable |
| tout_ie | input | 1 | Character-timeout interrupt enable |
| dma_req | output | 1 | Receive DMA request |
| tout_irq | output | 1 | Character-timeout interrupt |
| overrun | output | 1 | Sticky overrun flag |
| status_rd | input | 1 | Status read strobe, clears overrun |

## Verification
The assertions assume that `bit_tick` pulses last one clock each. They also assume that `trig_sel`, `dma_en` and `tout_ie` are stable while they are checked, and that `status_rd` is a one-cycle strobe.

The stimulus changes every input only on the falling clock edge. Each byte and each pop is held for exactly one cycle. Ticks are issued one per two clocks, so the silence window is counted purely in ticks. Overrun is reached only by filling the buffer completely, and then pushing one more byte.

// File: rtl/uart_rxbuf_pkg.sv
`timescale 1ns/1ps
package uart_rxbuf_pkg;
  typedef enum logic [1:0] {
    LVL_ONE   = 2'd0,
    LVL_EIGHT = 2'd1,
    LVL_SIXTN = 2'd2,
    LVL_THRTY = 2'd3
  } lvl_sel_e;

  localparam int unsigned LVL_A = 1;
  localparam int unsigned LVL_B = 8;
  localparam int unsigned LVL_C = 16;
  localparam int unsigned LVL_D = 32;
endpackage

// File: rtl/uart_rxbuf_store.sv
`timescale 1ns/1ps
module uart_rxbuf_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rptr];
  assign count_o = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2: a push into a full buffer with no pop leaves it full, nothing overwritten
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i) |=> full_o);
  // R1: a lone pop lowers the count by one
  assert_pop_lowers_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/uart_rxbuf_trig.sv
`timescale 1ns/1ps
module uart_rxbuf_trig
  import uart_rxbuf_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    sel_i,
  input  logic          en_i,
  output logic          req_o
);
  logic [CW-1:0] level;
  lvl_sel_e      sel;

  assign sel = lvl_sel_e'(sel_i);

  always_comb begin
    case (sel)
      LVL_ONE:   level = CW'(LVL_A);
      LVL_EIGHT: level = CW'(LVL_B);
      LVL_SIXTN: level = CW'(LVL_C);
      default:   level = CW'(LVL_D);
    endcase
  end

  assign req_o = en_i && (count_i >= level);

  // R4: the request never stands while the buffer is empty
  assert_no_req_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0) |-> !req_o);
endmodule

// File: rtl/uart_rxbuf_tmo.sv
`timescale 1ns/1ps
module uart_rxbuf_tmo #(
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned IDLE_CHARS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick_i,
  input  logic activity_i,
  input  logic nonempty_i,
  output logic flag_o
);
  localparam int unsigned LIMIT = BITS_PER_CHAR * IDLE_CHARS;
  localparam int unsigned TW    = $clog2(LIMIT + 1);

  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      flag_o   <= 1'b0;
    end else if (activity_i || !nonempty_i) begin
      idle_cnt <= '0;
      flag_o   <= 1'b0;
    end else if (bit_tick_i && !flag_o) begin
      if (idle_cnt == TW'(LIMIT - 1)) begin
        flag_o   <= 1'b1;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R6: the indication only stands over a non-empty buffer
  assert_flag_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |-> nonempty_i);
  // R8: any byte or pop clears the indication
  assert_clear_on_activity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    activity_i |=> !flag_o);
endmodule

// File: rtl/uart_rxbuf.sv
`timescale 1ns/1ps
module uart_rxbuf #(
  parameter int unsigned W             = 8,
  parameter int unsigned DEPTH         = 64,
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned IDLE_CHARS    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         bit_tick,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready,
  input  logic [1:0]   trig_sel,
  input  logic         dma_en,
  input  logic         tout_ie,
  output logic         dma_req,
  output logic         tout_irq,
  input  logic         status_rd,
  output logic         overrun
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] count;
  logic          full, empty, tout_flag, pop;

  assign pop      = rd_ready && !empty;
  assign in_ready = !full;
  assign rd_valid = !empty;

  uart_rxbuf_store #(.W(W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .push_i(in_valid), .din_i(in_data),
    .pop_i(rd_ready), .dout_o(rd_data), .count_o(count),
    .full_o(full), .empty_o(empty)
  );

  uart_rxbuf_trig #(.CW(CW)) trig_i (
    .clk(clk), .rst_n(rst_n), .count_i(count), .sel_i(trig_sel),
    .en_i(dma_en), .req_o(dma_req)
  );

  uart_rxbuf_tmo #(.BITS_PER_CHAR(BITS_PER_CHAR), .IDLE_CHARS(IDLE_CHARS)) tmo_i (
    .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick),
    .activity_i(in_valid || pop), .nonempty_i(!empty), .flag_o(tout_flag)
  );

  assign tout_irq = tout_flag && tout_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                overrun <= 1'b0;
    else if (in_valid && full) overrun <= 1'b1;
    else if (status_rd)        overrun <= 1'b0;
  end

  // R3: a request implies stored data
  assert_dma_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rd_valid);
  // R2: overrun is sticky until a status read
  assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !status_rd) |=> overrun);
  // R1: popping the last byte drops data-ready
  assert_last_pop_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(1) && rd_ready && !in_valid) |=> !rd_valid);
endmodule

// File: tb/uart_rxbuf_tb_top.sv
`timescale 1ns/1ps
module uart_rxbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       bit_tick = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_ready = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic       dma_en = 1'b0;
  logic       tout_ie = 1'b0;
  logic       dma_req, tout_irq, overrun;
  logic       status_rd = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  uart_rxbuf dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bit_tick(bit_tick), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready), .trig_sel(trig_sel),
    .dma_en(dma_en), .tout_ie(tout_ie), .dma_req(dma_req),
    .tout_irq(tout_irq), .status_rd(status_rd), .overrun(overrun)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [6:0] fill;
    logic       req;
  } vec_t;

  // R3/R4 threshold vectors: select, bytes stored, expected request
  localparam vec_t VECS [8] = '{
    '{2'd0, 7'd0,  1'b0}, '{2'd0, 7'd1,  1'b1},
    '{2'd1, 7'd7,  1'b0}, '{2'd1, 7'd8,  1'b1},
    '{2'd2, 7'd15, 1'b0}, '{2'd2, 7'd16, 1'b1},
    '{2'd3, 7'd31, 1'b0}, '{2'd3, 7'd32, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; rd_ready = 1'b0; bit_tick = 1'b0; status_rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 rd_valid", rd_valid, 0);
    chk("R9 dma_req", dma_req, 0);
    chk("R9 tout_irq", tout_irq, 0);
    chk("R9 overrun", overrun, 0);
    chk("R2 in_ready", in_ready, 1);

    // R3/R4 vector walk
    for (int v = 0; v < 8; v++) begin
      do_reset();
      trig_sel = VECS[v].sel;
      dma_en = 1'b1;
      for (int i = 0; i < int'(VECS[v].fill); i++) push(8'(i));
      @(negedge clk);
      chk(VECS[v].req ? "R3 req at level" : "R4 no req below level", dma_req, VECS[v].req);
      chk("R4 bytes kept", rd_valid, VECS[v].fill != 0);
    end

    // R1 ordering and data-ready
    do_reset();
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) pop_chk("R1 order", 8'hA0 + 8'(i));
    chk("R1 rd_valid after last pop", rd_valid, 0);

    // R5 dma_en toggling keeps data
    do_reset();
    trig_sel = 2'd1;
    dma_en = 1'b0;
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    chk("R5 masked", dma_req, 0);
    for (int i = 0; i < 4; i++) begin @(negedge clk); dma_en = ~dma_en; end
    dma_en = 1'b1;
    @(negedge clk);
    chk("R5 req restored", dma_req, 1);
    pop_chk("R5 data intact", 8'h10);
    chk("R4 below level after pop", dma_req, 0);
    for (int i = 1; i < 8; i++) pop_chk("R5 data intact", 8'h10 + 8'(i));
    chk("R5 count intact", rd_valid, 0);

    // R6/R8 timeout
    do_reset();
    tout_ie = 1'b1;
    ticks(50);
    chk("R6 no timeout empty", tout_irq, 0);
    push(8'h55); push(8'h66);
    ticks(39);
    chk("R6 before 40 ticks", tout_irq, 0);
    ticks(1);
    chk("R6 at 40 ticks", tout_irq, 1);
    pop_chk("R8 pop data", 8'h55);
    chk("R8 cleared by pop", tout_irq, 0);
    ticks(39);
    chk("R8 restart count", tout_irq, 0);
    ticks(1);
    chk("R6 fires again", tout_irq, 1);
    push(8'h77);
    chk("R8 cleared by byte", tout_irq, 0);

    // R7 enable gating
    tout_ie = 1'b0;
    ticks(40);
    chk("R7 masked", tout_irq, 0);
    @(negedge clk); tout_ie = 1'b1;
    @(negedge clk);
    chk("R7 pending shown", tout_irq, 1);

    // R2 overrun
    do_reset();
    for (int i = 0; i < 64; i++) push(8'(i));
    chk("R2 in_ready full", in_ready, 0);
    push(8'hEE);
    chk("R2 overrun set", overrun, 1);
    ticks(2);
    chk("R2 overrun sticky", overrun, 1);
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R2 overrun cleared", overrun, 0);
    for (int i = 0; i < 64; i++) pop_chk("R2 no overwrite", 8'(i));
    chk("R2 dropped byte absent", rd_valid, 0);

    finish_run();
  end
endmodule